// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block owns the housekeeping traffic of a four-bank synchronous DRAM. Out of reset it holds off every command for a settling pause of a parameterised length. It then asks a command arbiter for a fixed script: a precharge of all banks, two auto-refresh commands and a mode-register load. After the mode-register load it waits out the load-to-command gap and then raises `ready`. The pause, the refresh interval and the self-refresh exit delay are given in nanoseconds or microseconds together with the clock period, and the block turns them into clock counts when it is elaborated.

While ready, a timer produces one refresh obligation per average refresh interval, which is the retention time divided by the row count. Obligations accumulate in a saturating counter that holds at most eight. The block requests an auto-refresh whenever the counter is non-zero, and it raises `urgent` when the counter is full. If an obligation arrives while the counter is full, the retention budget is treated as broken. The block then drops `ready`, reissues the two wake-up refreshes and resumes without reloading the mode register.

Self-refresh entry is requested when the host asks for it and nothing is owed. Exit is requested on demand and is followed by a timed wait before `ready` returns. Every command uses the same handshake. The request is held until a grant arrives, and the command counts as finished when the arbiter signals done.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset `cmd_req`, `ready`, `urgent`, `in_sr` are low and `owed_count` is 0; the first request (code 1, precharge-all) rises exactly PAUSE_CYC clock edges after reset is released, and nothing is requested before it.
- R2: A request keeps `cmd_req` high with an unchanged `cmd_code` until the edge that samples `arb_grant`; it then waits for `arb_done`. A grant with no request pending, or a done with no granted command, has no effect. Codes: 0 none, 1 precharge-all, 2 auto-refresh, 3 mode load, 4 self-refresh entry, 5 self-refresh exit.
- R3: The power-up script is requested in the order 1, 2, 2, 3, with each request raised in the cycle after the previous command's done.
- R4: `ready` rises on the TMRD_CYC-th clock edge after the edge that samples done for the mode load.
- R5: While ready, `owed_count` grows by one every REFI_CYC cycles, and the first obligation arrives REFI_CYC edges after `ready` rises.
- R6: While ready and idle with `owed_count` > 0, code 2 is requested. Each completed refresh lowers the count by one. An obligation and a completion on the same edge leave the count unchanged.
- R7: `owed_count` never exceeds 8, and `urgent` is high exactly when it equals 8.
- R8: An obligation arriving at a count of 8 drops `ready` and clears the count. Any ungranted request is replaced by code 2. Exactly two code-2 commands are then run, after which `ready` returns with no code 3.
- R9: When ready, idle, nothing owed and `sr_enter` is high, code 4 is requested. Its completion raises `in_sr`, lowers `ready` and clears the count. No obligations accrue while `in_sr` is high.
- R10: With `in_sr` high and `sr_exit` high, code 5 is requested. `ready` returns on the TXSR_CYC-th edge after the edge that samples its done.
- R11: The choice made when idle follows this priority: an overrun recovery first, then owed refreshes, then self-refresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_grant | input | 1 | Arbiter accepts the pending request |
| arb_done | input | 1 | Arbiter reports the granted command issued |
| sr_enter | input | 1 | Host asks to enter self-refresh |
| sr_exit | input | 1 | Host asks to leave self-refresh |
| cmd_req | output | 1 | A command is waiting for a grant |
| cmd_code | output | 3 | Command being requested or in flight |
| ready | output | 1 | Normal operation permitted |
| urgent | output | 1 | Owed-refresh counter is full |
| owed_count | output | $clog2(MAX_OWED+1) | Refreshes owed but not yet issued |
| in_sr | output | 1 | Device is in self-refresh |

## Verification
A corrupted sequencer state appears within a cycle or two as a wrong `cmd_code`, as `ready` rising early or late, or as a missing script step. A miscounted timer moves the first request, the rise of `ready` or the arrival of obligations by whole cycles. A wrong owed count changes `owed_count` and `urgent` directly, and it also changes how many refreshes are requested before self-refresh entry or overrun recovery. The bench's behavioural model predicts every port on every clock, so any divergence is reported in the cycle it first shows at the ports.

// File: rtl/dram_rs_pkg.sv
package dram_rs_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PREALL = 3'd1,
        CMD_AREF   = 3'd2,
        CMD_MODE   = 3'd3,
        CMD_SR_IN  = 3'd4,
        CMD_SR_OUT = 3'd5
    } rs_cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE, ST_PREALL, ST_AREF1, ST_AREF2, ST_MODE,
        ST_MRD, ST_RUN, ST_SELF, ST_XSR
    } rs_state_e;

    typedef struct packed {
        rs_cmd_e code;
        logic    granted;
    } rs_hs_t;

    // Round a duration in ns up to whole clock cycles, at least one.
    function automatic int cyc_ceil(longint ns, longint clk_ps);
        longint c;
        c = (ns * 64'sd1000 + clk_ps - 64'sd1) / clk_ps;
        return (c < 64'sd1) ? 1 : int'(c);
    endfunction

    // Average refresh spacing in cycles: retention / rows, rounded down.
    function automatic int refi_cyc(longint ret_us, longint rows, longint clk_ps);
        longint c;
        c = (ret_us * 64'sd1000000) / (rows * clk_ps);
        return (c < 64'sd1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/rs_timer.sv
module rs_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign expired = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (expired) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs_owed.sv
module rs_owed #(
    parameter int MAX = 8,
    localparam int OW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          dec,
    input  logic          clr,
    output logic [OW-1:0] count,
    output logic          urgent,
    output logic          overrun
);
    localparam logic [OW-1:0] CAP = OW'(MAX);

    assign urgent = (count == CAP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            unique case ({tick, dec})
                2'b10: if (count == CAP) overrun <= 1'b1;
                       else              count   <= count + 1'b1;
                2'b01: if (count != '0)  count   <= count - 1'b1;
                default: ;
            endcase
        end
    end

    p_owed_cap_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (urgent && tick && !dec && !clr) |=> (urgent && overrun));
    p_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !dec && !clr && !urgent) |=> (count == $past(count) + 1'b1));
    p_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && !tick && !clr && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import dram_rs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    grant,
    input  logic    done,
    input  logic    sr_enter,
    input  logic    sr_exit,
    input  logic    pause_exp,
    input  logic    mrd_exp,
    input  logic    xsr_exp,
    input  logic    owed_nz,
    input  logic    overrun,
    output logic    cmd_req,
    output rs_cmd_e cmd_code,
    output logic    ready,
    output logic    in_sr,
    output logic    pause_en,
    output logic    mrd_en,
    output logic    xsr_en,
    output logic    run_en,
    output logic    owed_dec,
    output logic    owed_clr
);
    rs_state_e st_q, st_d;
    rs_hs_t    hs_q, hs_d;
    logic      rewake_q, rewake_d;
    logic      fin;

    assign cmd_req  = (hs_q.code != CMD_NONE) && !hs_q.granted;
    assign cmd_code = hs_q.code;
    assign fin      = hs_q.granted && done;
    assign ready    = (st_q == ST_RUN);
    assign in_sr    = (st_q == ST_SELF);
    assign pause_en = (st_q == ST_PAUSE);
    assign mrd_en   = (st_q == ST_MRD);
    assign xsr_en   = (st_q == ST_XSR);
    assign run_en   = ready;
    assign owed_dec = ready && fin && (hs_q.code == CMD_AREF);

    always_comb begin
        st_d     = st_q;
        hs_d     = hs_q;
        rewake_d = rewake_q;
        owed_clr = 1'b0;
        if (cmd_req && grant) hs_d.granted = 1'b1;
        if (fin)              hs_d = '{code: CMD_NONE, granted: 1'b0};
        unique case (st_q)
            ST_PAUSE:  if (pause_exp) begin st_d = ST_PREALL; hs_d.code = CMD_PREALL; end
            ST_PREALL: if (fin) begin st_d = ST_AREF1; hs_d.code = CMD_AREF; end
            ST_AREF1:  if (fin) begin st_d = ST_AREF2; hs_d.code = CMD_AREF; end
            ST_AREF2:  if (fin) begin
                           if (rewake_q) begin st_d = ST_RUN; rewake_d = 1'b0; end
                           else begin st_d = ST_MODE; hs_d.code = CMD_MODE; end
                       end
            ST_MODE:   if (fin) st_d = ST_MRD;
            ST_MRD:    if (mrd_exp) st_d = ST_RUN;
            ST_RUN: begin
                if (overrun && !hs_q.granted) begin
                    st_d      = ST_AREF1;
                    hs_d.code = CMD_AREF;
                    rewake_d  = 1'b1;
                    owed_clr  = 1'b1;
                end else if (hs_q.code == CMD_NONE) begin
                    if (owed_nz)       hs_d.code = CMD_AREF;
                    else if (sr_enter) hs_d.code = CMD_SR_IN;
                end else if (fin && hs_q.code == CMD_SR_IN) begin
                    st_d     = ST_SELF;
                    owed_clr = 1'b1;
                end
            end
            ST_SELF: begin
                if (hs_q.code == CMD_NONE) begin
                    if (sr_exit) hs_d.code = CMD_SR_OUT;
                end else if (fin) st_d = ST_XSR;
            end
            ST_XSR:    if (xsr_exp) st_d = ST_RUN;
            default:   st_d = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_PAUSE;
            hs_q     <= '{code: CMD_NONE, granted: 1'b0};
            rewake_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            hs_q     <= hs_d;
            rewake_q <= rewake_d;
        end
    end

    p_quiet_pause_r1: assert property (@(posedge clk) disable iff (rst)
        pause_en |-> (!cmd_req && !ready));
    p_hold_req_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !grant && !overrun) |=> (cmd_req && $stable(cmd_code)));
    p_mrd_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MODE && fin) |=> (!ready && !cmd_req));
    p_rewake_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && overrun && !hs_q.granted) |=> (!ready && cmd_code == CMD_AREF));
    p_self_empty_r9: assert property (@(posedge clk) disable iff (rst)
        in_sr |-> !owed_nz);
    p_exit_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (in_sr && fin) |=> (!ready && !in_sr));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rs_pkg::*;
#(
    parameter int CLK_PS   = 10000,
    parameter int PAUSE_NS = 100000,
    parameter int RET_US   = 64000,
    parameter int ROWS     = 8192,
    parameter int TXSR_NS  = 75,
    parameter int TMRD_CYC = 2,
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arb_grant,
    input  logic          arb_done,
    input  logic          sr_enter,
    input  logic          sr_exit,
    output logic          cmd_req,
    output logic [2:0]    cmd_code,
    output logic          ready,
    output logic          urgent,
    output logic [OW-1:0] owed_count,
    output logic          in_sr
);
    localparam int PAUSE_CYC = cyc_ceil(longint'(PAUSE_NS), longint'(CLK_PS));
    localparam int REFI_CYC  = refi_cyc(longint'(RET_US), longint'(ROWS), longint'(CLK_PS));
    localparam int TXSR_CYC  = cyc_ceil(longint'(TXSR_NS), longint'(CLK_PS));

    logic    pause_en, mrd_en, xsr_en, run_en;
    logic    pause_exp, mrd_exp, xsr_exp, refi_exp;
    logic    owed_dec, owed_clr, overrun;
    rs_cmd_e code_w;

    rs_timer #(.LIMIT(PAUSE_CYC)) i_pause (.clk(clk), .rst(rst), .en(pause_en), .expired(pause_exp));
    rs_timer #(.LIMIT(TMRD_CYC))  i_mrd   (.clk(clk), .rst(rst), .en(mrd_en),   .expired(mrd_exp));
    rs_timer #(.LIMIT(TXSR_CYC))  i_xsr   (.clk(clk), .rst(rst), .en(xsr_en),   .expired(xsr_exp));
    rs_timer #(.LIMIT(REFI_CYC))  i_refi  (.clk(clk), .rst(rst), .en(run_en),   .expired(refi_exp));

    rs_owed #(.MAX(MAX_OWED)) i_owed (
        .clk(clk), .rst(rst), .tick(refi_exp), .dec(owed_dec), .clr(owed_clr),
        .count(owed_count), .urgent(urgent), .overrun(overrun)
    );

    rs_seq i_seq (
        .clk(clk), .rst(rst), .grant(arb_grant), .done(arb_done),
        .sr_enter(sr_enter), .sr_exit(sr_exit),
        .pause_exp(pause_exp), .mrd_exp(mrd_exp), .xsr_exp(xsr_exp),
        .owed_nz(|owed_count), .overrun(overrun),
        .cmd_req(cmd_req), .cmd_code(code_w), .ready(ready), .in_sr(in_sr),
        .pause_en(pause_en), .mrd_en(mrd_en), .xsr_en(xsr_en), .run_en(run_en),
        .owed_dec(owed_dec), .owed_clr(owed_clr)
    );

    assign cmd_code = code_w;
endmodule

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
    localparam int CPS   = 10000;
    localparam int PNS   = 200;
    localparam int RUS   = 12;
    localparam int NROWS = 40;
    localparam int XNS   = 75;
    localparam int TMRD  = 2;
    localparam int MAXO  = 8;
    localparam int P_CYC = (PNS * 1000 + CPS - 1) / CPS;
    localparam int R_CYC = (RUS * 1000000) / (NROWS * CPS);
    localparam int X_CYC = (XNS * 1000 + CPS - 1) / CPS;

    logic clk = 0, rst = 1, grant = 0, done = 0, sr_enter = 0, sr_exit = 0;
    logic cmd_req, ready, urgent, in_sr;
    logic [2:0] cmd_code;
    logic [3:0] owed_count;

    dram_refresh_sched #(.CLK_PS(CPS), .PAUSE_NS(PNS), .RET_US(RUS), .ROWS(NROWS),
        .TXSR_NS(XNS), .TMRD_CYC(TMRD), .MAX_OWED(MAXO)) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .arb_grant(grant), .arb_done(done),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .cmd_req(cmd_req), .cmd_code(cmd_code),
        .ready(ready), .urgent(urgent), .owed_count(owed_count), .in_sr(in_sr));

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_ph, m_t, m_code, m_g, m_owed, m_ovr, m_rw, m_rt;
    int nph, ncode, ng;
    bit req, fin, tick, clr, dec;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_t = 0; m_code = 0; m_g = 0; m_owed = 0; m_ovr = 0; m_rw = 0; m_rt = 0;
            cyc = 0;
        end else begin
            cyc++;
            req  = (m_code != 0) && (m_g == 0);
            fin  = (m_g != 0) && done;
            tick = (m_ph == 6) && (m_rt == R_CYC - 1);
            nph = m_ph; ncode = m_code; ng = m_g; clr = 0;
            if (req && grant) ng = 1;
            if (fin) begin ng = 0; ncode = 0; end
            case (m_ph)
                0: if (m_t == P_CYC - 1) begin nph = 1; ncode = 1; end
                1: if (fin) begin nph = 2; ncode = 2; end
                2: if (fin) begin nph = 3; ncode = 2; end
                3: if (fin) begin
                       if (m_rw != 0) begin nph = 6; m_rw = 0; end
                       else begin nph = 4; ncode = 3; end
                   end
                4: if (fin) nph = 5;
                5: if (m_t == TMRD - 1) nph = 6;
                6: begin
                    if (m_ovr != 0 && m_g == 0) begin nph = 2; ncode = 2; m_rw = 1; clr = 1; end
                    else if (m_code == 0) begin
                        if (m_owed > 0) ncode = 2;
                        else if (sr_enter) ncode = 4;
                    end else if (fin && m_code == 4) begin nph = 7; clr = 1; end
                end
                7: if (m_code == 0) begin if (sr_exit) ncode = 5; end
                   else if (fin) nph = 8;
                8: if (m_t == X_CYC - 1) nph = 6;
                default: ;
            endcase
            dec = (m_ph == 6) && fin && (m_code == 2);
            if (clr) begin m_owed = 0; m_ovr = 0; end
            else if (tick && !dec) begin
                if (m_owed == MAXO) m_ovr = 1; else m_owed++;
            end else if (dec && !tick && m_owed > 0) m_owed--;
            m_rt = (m_ph == 6) ? (tick ? 0 : m_rt + 1) : 0;
            m_t  = (nph != m_ph) ? 0 : m_t + 1;
            m_ph = nph; m_code = ncode; m_g = ng;
        end
    end

    // Compare every port with the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(cmd_req == ((m_code != 0) && (m_g == 0)), "R2", "cmd_req", int'(cmd_req), int'((m_code != 0) && (m_g == 0)));
            check(int'(cmd_code) == m_code, "R3", "cmd_code", int'(cmd_code), m_code);
            check(ready == (m_ph == 6), "R4", "ready", int'(ready), int'(m_ph == 6));
            check(int'(owed_count) == m_owed, "R5", "owed_count", int'(owed_count), m_owed);
            check(urgent == (m_owed == MAXO), "R7", "urgent", int'(urgent), int'(m_owed == MAXO));
            check(in_sr == (m_ph == 7), "R9", "in_sr", int'(in_sr), int'(m_ph == 7));
        end
    end

    // Arbiter model
    int gdel = 2, ddel = 1, gw = 0, dw = 0, pcode = 0;
    bit blk = 0, pend = 0, spur_g = 0, spur_d = 0;
    int glog[$];
    int mode_done_edge = -1, exit_done_edge = -1;

    always @(negedge clk) begin
        grant = 0; done = 0;
        if (!rst) begin
            if (pend) begin
                if (dw >= ddel) begin
                    done = 1; pend = 0;
                    if (pcode == 3) mode_done_edge = cyc + 1;
                    if (pcode == 5) exit_done_edge = cyc + 1;
                end else dw++;
            end
            if (cmd_req && !(blk && cmd_code == 3'd2)) begin
                if (gw >= gdel) begin
                    grant = 1; gw = 0; pend = 1; dw = 0; pcode = int'(cmd_code);
                    glog.push_back(int'(cmd_code));
                end else gw++;
            end else gw = 0;
        end
        grant = grant | spur_g;
        done  = done | spur_d;
    end

    // Port monitor
    int ready_rises[$];
    int first_req = -1, first_code = -1, first_owed_rise = -1;
    bit prev_ready = 0;
    int prev_owed = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ready && !prev_ready) ready_rises.push_back(cyc);
            if (cmd_req && first_req < 0) begin first_req = cyc; first_code = int'(cmd_code); end
            if (owed_count != 0 && prev_owed == 0 && first_owed_rise < 0) first_owed_rise = cyc;
            prev_ready = ready;
            prev_owed  = int'(owed_count);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int mark;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check(!cmd_req && !ready && !urgent && !in_sr && owed_count == 0, "R1", "reset outputs",
              int'({cmd_req, ready, urgent, in_sr}), 0);
        rst = 0;
        step(5);
        spur_g = 1; spur_d = 1;
        step(1);
        spur_g = 0; spur_d = 0;
        step(1);
        // R2: stray grant/done during the pause have no effect
        check(!cmd_req && !ready, "R2", "stray handshake ignored", int'({cmd_req, ready}), 0);
        while (ready_rises.size() < 1) step(1);
        check(first_req == P_CYC, "R1", "first request edge", first_req, P_CYC);
        check(first_code == 1, "R1", "first request code", first_code, 1);
        check(glog.size() >= 4 && glog[0] == 1 && glog[1] == 2 && glog[2] == 2 && glog[3] == 3,
              "R3", "script order (size)", glog.size(), 4);
        check(ready_rises[0] - mode_done_edge == TMRD, "R4", "mode wait", ready_rises[0] - mode_done_edge, TMRD);
        while (first_owed_rise < 0) step(1);
        check(first_owed_rise == ready_rises[0] + R_CYC, "R5", "first obligation edge",
              first_owed_rise, ready_rises[0] + R_CYC);
        step(15);
        check(owed_count == 0, "R6", "owed drained", int'(owed_count), 0);
        check(glog.size() >= 5 && glog[4] == 2, "R6", "refresh code", (glog.size() >= 5) ? glog[4] : -1, 2);

        // R7: withhold refresh grants until the counter fills
        blk = 1;
        while (!urgent) step(1);
        check(owed_count == MAXO, "R7", "saturated count", int'(owed_count), MAXO);
        mark = glog.size();
        while (ready) step(1);
        // R8: overrun recovery
        check(owed_count == 0, "R8", "count cleared", int'(owed_count), 0);
        check(cmd_req && cmd_code == 3'd2, "R8", "rewake request code", int'(cmd_code), 2);
        blk = 0;
        while (!ready) step(1);
        check(glog.size() - mark == 2 && glog[mark] == 2 && glog[mark + 1] == 2, "R8",
              "rewake commands", glog.size() - mark, 2);

        // R9: self-refresh entry
        sr_enter = 1;
        while (!in_sr) step(1);
        sr_enter = 0;
        check(!ready && glog[glog.size() - 1] == 4, "R9", "entry code", glog[glog.size() - 1], 4);
        step(100);
        check(in_sr && owed_count == 0 && !cmd_req, "R9", "no obligations in self-refresh",
              int'(owed_count), 0);

        // R10: self-refresh exit
        sr_exit = 1;
        while (!cmd_req) step(1);
        check(cmd_code == 3'd5, "R10", "exit code", int'(cmd_code), 5);
        mark = ready_rises.size();
        while (!ready) step(1);
        sr_exit = 0;
        check(ready_rises[mark] - exit_done_edge == X_CYC, "R10", "exit wait",
              ready_rises[mark] - exit_done_edge, X_CYC);

        // R11: owed refreshes outrank self-refresh entry
        blk = 1;
        while (owed_count < 2) step(1);
        sr_enter = 1;
        step(3);
        mark = glog.size();
        blk = 0;
        while (!in_sr) step(1);
        sr_enter = 0;
        check(glog[mark] == 2, "R11", "refresh before entry", glog[mark], 2);
        check(glog[glog.size() - 1] == 4, "R11", "entry after refreshes", glog[glog.size() - 1], 4);
        step(2);

        finished = 1;
        summary();
        $finish;
    end
endmodule